// File: doc/BRIEF.md
# Iterative One-or-Two Ones Detector

This block is a purely combinational array of identical cells. Each cell reads one bit of the input vector. Cell i asserts its output when the number of ones among input bits 0 through i, its own bit included, is exactly one or exactly two. The array computes this in space, not over time. Each cell passes a 2-bit tally to its neighbour at the next higher index. The tally says how many ones have been seen so far and saturates at "three or more". Cell 0 receives the empty tally.

The tally has four states with this encoding: none = 2'b00, one = 2'b01, two = 2'b11, many = 2'b10. A set input bit moves the tally one step along none → one → two → many. A clear bit leaves it unchanged, and "many" never changes. The cell output is taken from the updated tally.

Two cell implementations are available through a parameter: a case-based cell table and a reduced sum-of-products form. They are interchangeable and produce the same outputs for every input. The vector width is a parameter.

Top module: `ones_window_array`

## Requirements
- R1: For every index i, z[i] is 1 if and only if the number of ones in x[i:0] is 1 or 2.
- R2: The first cell starts from the empty tally, so z[0] always equals x[0].
- R3: Once three or more ones have been seen in x[i:0], z[i] and every higher output are 0, whatever the higher input bits are.
- R4: A clear input bit x[i], for i > 0, leaves the tally unchanged, so z[i] equals z[i-1].
- R5: The table-based cell (CELL_STYLE = 0) and the equation-based cell (CELL_STYLE = 1) produce identical z for every x.
- R6: When x is all zeros, z is all zeros.
- R7: The array holds no state. z depends only on the present x, and a new x takes effect without any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | Input bits; bit 0 feeds the first cell |
| z | output | WIDTH | z[i] set when x[i:0] holds one or two ones |

## Verification
The hardest condition to reach is the saturated tally. It needs three ones in the low bits, followed by higher bits that would change the output again if the count wrapped or stepped back. The stimulus applies every one of the 256 vectors at width eight. This covers every position at which saturation can begin, followed by every suffix pattern. Both cell styles run side by side on the same input, so any disagreement between the table and the equations shows at the outputs on the vector where it occurs.

// File: rtl/ones_window_pkg.sv
package ones_window_pkg;

   // Saturating tally carried between cells (Gray-ordered codes)
   typedef enum logic [1:0] {
      TALLY_NONE = 2'b00,
      TALLY_ONE  = 2'b01,
      TALLY_TWO  = 2'b11,
      TALLY_MANY = 2'b10
   } tally_e;

   localparam int TALLY_W = 2;

   // Cell style selectors
   localparam int STYLE_TABLE = 0;
   localparam int STYLE_EQN   = 1;

   // Whether a tally lies in the flagged window
   function automatic logic in_window(input tally_e t);
      return (t == TALLY_ONE) || (t == TALLY_TWO);
   endfunction

endpackage

// File: rtl/ow_cell_table.sv
module ow_cell_table
   import ones_window_pkg::*;
(
   input  logic   bit_in,
   input  tally_e tally_in,
   output tally_e tally_out,
   output logic   flag
);

   always_comb begin
      unique case ({tally_in, bit_in})
         {TALLY_NONE, 1'b0}: tally_out = TALLY_NONE;
         {TALLY_NONE, 1'b1}: tally_out = TALLY_ONE;
         {TALLY_ONE,  1'b0}: tally_out = TALLY_ONE;
         {TALLY_ONE,  1'b1}: tally_out = TALLY_TWO;
         {TALLY_TWO,  1'b0}: tally_out = TALLY_TWO;
         {TALLY_TWO,  1'b1}: tally_out = TALLY_MANY;
         {TALLY_MANY, 1'b0}: tally_out = TALLY_MANY;
         default:            tally_out = TALLY_MANY;
      endcase
   end

   assign flag = in_window(tally_out);

endmodule

// File: rtl/ow_cell_eqn.sv
module ow_cell_eqn
   import ones_window_pkg::*;
(
   input  logic   bit_in,
   input  tally_e tally_in,
   output tally_e tally_out,
   output logic   flag
);

   logic y1, y0, n1, n0;

   assign y1 = tally_in[1];
   assign y0 = tally_in[0];

   // Reduced next-tally equations for the chosen code assignment
   assign n1 = y1 | (bit_in & y0);
   assign n0 = (~y1 & (y0 | bit_in)) | (y1 & y0 & ~bit_in);

   assign tally_out = tally_e'({n1, n0});
   // Low code bit marks both window states (01, 11)
   assign flag      = n0;

endmodule

// File: rtl/ow_cell.sv
module ow_cell
   import ones_window_pkg::*;
#(
   parameter int CELL_STYLE = STYLE_TABLE
) (
   input  logic   bit_in,
   input  tally_e tally_in,
   output tally_e tally_out,
   output logic   flag
);

   generate
      if (CELL_STYLE == STYLE_TABLE) begin : g_table
         ow_cell_table u_cell (
            .bit_in   (bit_in),
            .tally_in (tally_in),
            .tally_out(tally_out),
            .flag     (flag)
         );
      end else begin : g_eqn
         ow_cell_eqn u_cell (
            .bit_in   (bit_in),
            .tally_in (tally_in),
            .tally_out(tally_out),
            .flag     (flag)
         );
      end
   endgenerate

   always_comb begin
      // R3
      sat_hold_chk: assert (tally_in != TALLY_MANY || tally_out == TALLY_MANY);
      // R4
      zero_hold_chk: assert (bit_in || tally_out == tally_in);
      // R1
      step_move_chk: assert (!bit_in || tally_in == TALLY_MANY || tally_out != tally_in);
   end

endmodule

// File: rtl/ones_window_array.sv
module ones_window_array
   import ones_window_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int CELL_STYLE = STYLE_TABLE
) (
   input  logic [WIDTH-1:0] x,
   output logic [WIDTH-1:0] z
);

   localparam int LINKS = WIDTH + 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ones_window_array: WIDTH must be at least 1");
      end
      if (CELL_STYLE != STYLE_TABLE && CELL_STYLE != STYLE_EQN) begin : g_bad_style
         $error("ones_window_array: CELL_STYLE must be 0 or 1");
      end
   endgenerate

   tally_e link [LINKS];

   assign link[0] = TALLY_NONE;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         ow_cell #(.CELL_STYLE(CELL_STYLE)) u_cell (
            .bit_in   (x[i]),
            .tally_in (link[i]),
            .tally_out(link[i+1]),
            .flag     (z[i])
         );
      end
   endgenerate

   always_comb begin
      // R2
      first_cell_chk: assert (z[0] == x[0]);
      // R6
      quiet_input_chk: assert (x != '0 || z == '0);
   end

endmodule

// File: tb/sim_ones_window_array.sv
module sim_ones_window_array;

   localparam int W = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [W-1:0] x;
   logic [W-1:0] z_tab, z_eqn;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   ones_window_array #(.WIDTH(W), .CELL_STYLE(0)) u0 (.x(x), .z(z_tab));
   ones_window_array #(.WIDTH(W), .CELL_STYLE(1)) u1 (.x(x), .z(z_eqn));

   task automatic check(input bit ok, input string req,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s x=%b actual=%b expected=%b", req, x, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      x = '0;
      // R6: all-zero input, before any sweep
      @(negedge clk);
      check(z_tab == '0, "R6", z_tab, '0);
      check(z_eqn == '0, "R6", z_eqn, '0);

      for (int v = 0; v < (1 << W); v++) begin
         logic [W-1:0] exp, sat_mask, hold_exp;
         int run;
         @(posedge clk);
         x = v[W-1:0];
         @(negedge clk);
         run = 0;
         exp = '0;
         sat_mask = '0;
         for (int i = 0; i < W; i++) begin
            run += int'(x[i]);
            exp[i] = (run == 1 || run == 2);
            sat_mask[i] = (run >= 3);
         end
         // R7: output follows the present x only, within the same cycle
         // R1: window of one or two ones
         check(z_tab == exp, "R1/R7 table", z_tab, exp);
         check(z_eqn == exp, "R1/R7 eqn", z_eqn, exp);
         // R5: styles agree
         check(z_tab == z_eqn, "R5", z_eqn, z_tab);
         // R2: first cell
         check(z_tab[0] == x[0], "R2", {{(W-1){1'b0}}, z_tab[0]}, {{(W-1){1'b0}}, x[0]});
         // R3: saturated positions stay low
         check((z_tab & sat_mask) == '0, "R3", z_tab & sat_mask, '0);
         // R4: clear bit repeats previous output
         hold_exp = z_tab;
         for (int i = 1; i < W; i++)
            if (!x[i]) hold_exp[i] = z_tab[i-1];
         check(z_tab == hold_exp, "R4", z_tab, hold_exp);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule